// File: doc/BRIEF.md
# One-Producer, Many-Consumer Message Fan-Out Channel

This block takes messages from one producer and hands an identical copy of each to every one of several consumers. The producer side uses a push handshake with a ready indication, an empty-everywhere indication and a synchronous clear. Each consumer has its own valid, data and read-enable port. The data of the oldest unread message is always on that consumer's data lines, so a consumer can look at the message before it takes it.

All messages are kept once in a shared ring of slots. The channel tracks one write position and one read position per consumer. A slot becomes free again only when the slowest consumer has moved past it. A fast consumer can run ahead until it has drained everything. A lagging consumer throttles the producer. The clear input empties the channel for all consumers in one cycle.

Top module: `bcast_chan`

## Requirements
- R1: After reset, `put_rdy` and `put_sync` are 1 and every bit of `get_valid` is 0.
- R2: A message is stored only in a cycle where `put_wen` is 1, `put_rdy` is 1 and `put_clr` is 0. A `put_wen` pulse while `put_rdy` is 0 stores nothing, and that data never reaches any consumer.
- R3: Each consumer receives every stored message exactly once, in write order. A message written at a clock edge is visible (valid 1, data presented) from the next cycle onward.
- R4: Consumer i's data lines, bits [i*DW +: DW] of `get_data`, show its oldest unread message while `get_valid[i]` is 1. The data stays unchanged until that consumer pops, so a consumer can peek at it without taking it.
- R5: A pop by one consumer never changes the valid flag or the data presented to any other consumer.
- R6: `put_rdy` is 0 exactly when some consumer holds DEPTH unread messages. It returns to 1 once every consumer holds fewer than DEPTH.
- R7: `put_sync` is 1 exactly when no consumer holds an unread message.
- R8: A cycle with `put_clr` at 1 discards every stored message for all consumers. The next cycle shows all valids 0, `put_sync` 1 and `put_rdy` 1. A write in the same cycle as the clear is dropped.
- R9: A producer write and pops from any set of consumers may occur in the same cycle, and all of them take effect.
- R10: A read-enable on a consumer whose valid is 0 is ignored. That consumer stays empty, and its later messages arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| put_clr | input | 1 | Synchronous clear of all stored messages |
| put_wen | input | 1 | Producer write request |
| put_data | input | DW | Producer message |
| put_rdy | output | 1 | Channel can accept a message this cycle |
| put_sync | output | 1 | All consumers drained |
| get_ren | input | NCONS | Per-consumer pop request |
| get_valid | output | NCONS | Per-consumer message available |
| get_data | output | NCONS*DW | Per-consumer oldest unread message, consumer i at [i*DW +: DW] |

## Verification
A reference model keeps one message queue per consumer and is compared against every output in every cycle. Directed phases fill the channel with no pops, which separates the full condition from the drain of a single consumer. One consumer drains while the others hold, which shows whether the ready flag follows the slowest consumer or the fastest. Clear is applied together with a write, and pops are issued on empty consumers. A long seeded random phase then mixes skewed per-consumer pop rates with bursts of writes and rare clears. Any mix-up between the consumers' pointers or a lost wrap would show up in that phase as reordered or missing data.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
   // Width of a ring pointer including the wrap bit.
   function automatic int ptr_width(input int depth);
      return $clog2(depth) + 1;
   endfunction

   // Producer side action taken at a clock edge.
   typedef enum logic [1:0] {
      PUT_IDLE  = 2'd0,
      PUT_STORE = 2'd1,
      PUT_BLOCK = 2'd2,
      PUT_CLEAR = 2'd3
   } put_act_e;
endpackage

// File: rtl/bcast_store.sv
module bcast_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 4,
   parameter int NCONS = 2,
   parameter int AW    = 2
) (
   input  logic                clk,
   input  logic                we,
   input  logic [AW-1:0]       waddr,
   input  logic [DW-1:0]       wdata,
   input  logic [NCONS*AW-1:0] raddr,
   output logic [NCONS*DW-1:0] rdata
);
   logic [DW-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (we) slots[waddr] <= wdata;
   end

   for (genvar g = 0; g < NCONS; g++) begin : g_rport
      assign rdata[g*DW +: DW] = slots[raddr[g*AW +: AW]];
   end
endmodule

// File: rtl/bcast_rdptr.sv
module bcast_rdptr #(
   parameter int PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          ren,
   input  logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] rd_ptr,
   output logic [PW-1:0] unread,
   output logic          valid
);
   logic pop;

   assign unread = wr_ptr - rd_ptr;
   assign valid  = (unread != '0);
   assign pop    = ren && valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_ptr <= '0;
      else if (clr)    rd_ptr <= '0;
      else if (pop)    rd_ptr <= rd_ptr + 1'b1;
   end

   // R3: an accepted pop moves this consumer forward by exactly one slot
   p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ren && valid && !clr) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

   // R10: a read request on an empty consumer leaves its position alone
   p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !clr) |=> $stable(rd_ptr));
endmodule

// File: rtl/bcast_occ.sv
module bcast_occ #(
   parameter int NCONS = 2,
   parameter int DEPTH = 4,
   parameter int PW    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NCONS*PW-1:0] unread,
   output logic [PW-1:0]       worst,
   output logic                rdy,
   output logic                sync
);
   localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

   always_comb begin
      worst = '0;
      for (int i = 0; i < NCONS; i++) begin
         if (unread[i*PW +: PW] > worst) worst = unread[i*PW +: PW];
      end
   end

   assign rdy  = (worst != FULL_LVL);
   assign sync = (worst == '0);

   // R6: no consumer ever holds more than DEPTH unread messages
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      worst <= FULL_LVL);
endmodule

// File: rtl/bcast_chan.sv
module bcast_chan #(
   parameter int DW    = 8,
   parameter int DEPTH = 4,
   parameter int NCONS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                put_clr,
   input  logic                put_wen,
   input  logic [DW-1:0]       put_data,
   output logic                put_rdy,
   output logic                put_sync,
   input  logic [NCONS-1:0]    get_ren,
   output logic [NCONS-1:0]    get_valid,
   output logic [NCONS*DW-1:0] get_data
);
   import bcast_pkg::*;

   localparam int PW = ptr_width(DEPTH);
   localparam int AW = PW - 1;

   initial begin
      a_cons_min: assert (NCONS >= 2) else $error("NCONS must be at least 2");
      a_depth_pow2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      a_width_min: assert (DW >= 1) else $error("DW must be positive");
   end

   logic [PW-1:0]       wr_ptr;
   logic [NCONS*PW-1:0] rd_ptrs;
   logic [NCONS*PW-1:0] unread;
   logic [NCONS*AW-1:0] raddr;
   logic [PW-1:0]       worst;
   put_act_e            put_act;
   logic                store;

   always_comb begin
      if (put_clr)                 put_act = PUT_CLEAR;
      else if (put_wen && put_rdy) put_act = PUT_STORE;
      else if (put_wen)            put_act = PUT_BLOCK;
      else                         put_act = PUT_IDLE;
   end
   assign store = (put_act == PUT_STORE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     wr_ptr <= '0;
      else if (put_act == PUT_CLEAR)  wr_ptr <= '0;
      else if (store)                 wr_ptr <= wr_ptr + 1'b1;
   end

   for (genvar g = 0; g < NCONS; g++) begin : g_cons
      bcast_rdptr #(.PW(PW)) rdp_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (put_clr),
         .ren    (get_ren[g]),
         .wr_ptr (wr_ptr),
         .rd_ptr (rd_ptrs[g*PW +: PW]),
         .unread (unread[g*PW +: PW]),
         .valid  (get_valid[g])
      );
      assign raddr[g*AW +: AW] = rd_ptrs[g*PW +: AW];
   end

   bcast_store #(.DW(DW), .DEPTH(DEPTH), .NCONS(NCONS), .AW(AW)) store_i (
      .clk   (clk),
      .we    (store),
      .waddr (wr_ptr[AW-1:0]),
      .wdata (put_data),
      .raddr (raddr),
      .rdata (get_data)
   );

   bcast_occ #(.NCONS(NCONS), .DEPTH(DEPTH), .PW(PW)) occ_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .unread (unread),
      .worst  (worst),
      .rdy    (put_rdy),
      .sync   (put_sync)
   );

   // R2: a blocked producer cannot move the write position
   p_block_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!put_rdy && !put_clr) |=> $stable(wr_ptr));

   // R8: a clear leaves every consumer empty and the producer free
   p_clr_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      put_clr |=> (put_sync && put_rdy && get_valid == '0));

   // R7: drained state agrees with the per-consumer valid flags
   p_sync_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      put_sync == (get_valid == '0));

   // R3: a stored message makes every consumer valid on the next cycle
   p_store_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (store) |=> (get_valid == '1));
endmodule

// File: tb/bcast_chan_tb_top.sv
module bcast_chan_tb_top;
   localparam int DW = 8;
   localparam int DEPTH = 4;
   localparam int NCONS = 3;
   localparam int QSZ = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic put_clr = 1'b0;
   logic put_wen = 1'b0;
   logic [DW-1:0] put_data = '0;
   logic put_rdy, put_sync;
   logic [NCONS-1:0] get_ren = '0;
   logic [NCONS-1:0] get_valid;
   logic [NCONS*DW-1:0] get_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] mq [NCONS][QSZ];
   int head [NCONS];
   int tail [NCONS];

   always #5 clk = ~clk;

   bcast_chan #(.DW(DW), .DEPTH(DEPTH), .NCONS(NCONS)) dut_i (
      .clk(clk), .rst_n(rst_n), .put_clr(put_clr), .put_wen(put_wen),
      .put_data(put_data), .put_rdy(put_rdy), .put_sync(put_sync),
      .get_ren(get_ren), .get_valid(get_valid), .get_data(get_data)
   );

   function automatic int worst_cnt();
      int m = 0;
      for (int i = 0; i < NCONS; i++) if (tail[i] - head[i] > m) m = tail[i] - head[i];
      return m;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Compare all outputs with the model, then drive one cycle of stimulus.
   task automatic cyc(input bit clr, input bit wen, input logic [DW-1:0] d,
                      input logic [NCONS-1:0] ren, input string tag);
      int m;
      bit rdy_m;
      m = worst_cnt();
      rdy_m = (m < DEPTH);
      chk(tag, "put_rdy", int'(put_rdy), int'(rdy_m));
      chk(tag, "put_sync", int'(put_sync), int'(m == 0));
      for (int i = 0; i < NCONS; i++) begin
         chk(tag, $sformatf("valid[%0d]", i), int'(get_valid[i]), int'(tail[i] > head[i]));
         if (tail[i] > head[i])
            chk(tag, $sformatf("data[%0d]", i), int'(get_data[i*DW +: DW]),
                int'(mq[i][head[i] % QSZ]));
      end
      put_clr = clr; put_wen = wen; put_data = d; get_ren = ren;
      if (clr) begin
         for (int i = 0; i < NCONS; i++) head[i] = tail[i];
      end else begin
         for (int i = 0; i < NCONS; i++) if (ren[i] && tail[i] > head[i]) head[i]++;
         if (wen && rdy_m)
            for (int i = 0; i < NCONS; i++) begin
               mq[i][tail[i] % QSZ] = d;
               tail[i]++;
            end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NCONS; i++) begin head[i] = 0; tail[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      cyc(0, 0, 8'h00, 3'b000, "R1");
      // R3: fill with no pops
      for (int k = 0; k < DEPTH; k++) cyc(0, 1, 8'h10 + 8'(k), 3'b000, "R3");
      // R2: writes while full are dropped; R6 rdy low
      cyc(0, 1, 8'hEE, 3'b000, "R2");
      cyc(0, 1, 8'hEF, 3'b000, "R6");
      // R5: consumer 0 drains alone, others unchanged; rdy stays low (R6)
      for (int k = 0; k < DEPTH; k++) cyc(0, 0, 8'h00, 3'b001, "R5");
      cyc(0, 1, 8'hE0, 3'b000, "R6");
      // R4: peek, no pops for several cycles
      for (int k = 0; k < 3; k++) cyc(0, 0, 8'h00, 3'b000, "R4");
      // R6: the two slow consumers pop once; ready returns
      cyc(0, 0, 8'h00, 3'b110, "R6");
      cyc(0, 1, 8'h21, 3'b000, "R6");
      // R8: clear together with a write
      cyc(1, 1, 8'h99, 3'b000, "R8");
      cyc(0, 0, 8'h00, 3'b000, "R8");
      // R10: pops on empty consumers
      cyc(0, 0, 8'h00, 3'b111, "R10");
      cyc(0, 1, 8'h31, 3'b111, "R10");
      cyc(0, 0, 8'h00, 3'b000, "R10");
      // R9: write and pops in the same cycle, streaming
      for (int k = 0; k < 12; k++) cyc(0, 1, 8'h40 + 8'(k), 3'b111, "R9");
      for (int k = 0; k < 4; k++) cyc(0, 0, 8'h00, 3'b111, "R7");
      // R3: seeded random phase with skewed consumers
      begin
         int unsigned s;
         s = $urandom(32'd20240611);
         for (int k = 0; k < 4000; k++) begin
            logic [NCONS-1:0] r;
            bit c, w;
            for (int i = 0; i < NCONS; i++) r[i] = (($urandom % 8) < 3 + 2 * i);
            w = ($urandom % 4) != 0;
            c = ($urandom % 97) == 0;
            cyc(c, w, 8'($urandom), r, "R3");
         end
      end
      for (int k = 0; k < DEPTH + 1; k++) cyc(0, 0, 8'h00, 3'b111, "R7");
      cyc(0, 0, 8'h00, 3'b000, "R7");
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule